// File: doc/BRIEF.md
# Hibernate Entry and Wake Controller

This block moves the system into a low-power hibernate state when software writes the enter bit, and brings it back to normal operation on one chosen wake event. Software selects the wake source with a two-bit code. A push-button wake also needs its own enable bit. The polarity of the button is configurable. The other two sources are a pack-connect detect level and a periodic wake timer that counts a slow tick.

The enter bit reads back as set for the whole hibernate episode. Hardware clears it when the system is awake again, and at the same moment the block records which source woke it. The wake configuration is captured when hibernate is entered, so later changes to it have no effect until the next entry. If software asks to enter with no usable wake source, the request is refused and the enter bit stays clear.

Top module: `hibWakeCtrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `hibActive` and `enterBit` are 0 and `wakeCause` is 3 (no wake recorded yet).
- R2: A cycle with `enterWr` high while awake and idle, with a usable wake source, sets `enterBit` on the next cycle. `hibActive` rises one cycle after that. The entry handshake takes exactly one cycle.
- R3: A wake select of 3, or a select of 0 with `pbWakeEn` low, is not a usable source. `enterWr` then leaves `enterBit` at 0, and `hibActive` never rises.
- R4: With select 0 (button), the button input passes through a two-flop synchroniser. It must then be seen asserted on `DEBOUNCE_TICKS` consecutive `slowTick` pulses before it wakes the block. Any cycle in which it is seen released restarts the count.
- R5: `pbActiveLow` = 0 means the button is asserted when `pbIn` is 1. `pbActiveLow` = 1 means it is asserted when `pbIn` is 0.
- R6: With select 1 (pack connect), a high `packDetect` level wakes the block after the two-flop synchroniser.
- R7: With select 2 (timer), the counter reloads `timerPeriod` on every entry. `hibActive` stays high through `timerPeriod`−1 ticks and falls one cycle after tick number `timerPeriod`. A period of 0 wakes the block without any tick.
- R8: The select, the button enable and the button polarity are captured at entry. Sources other than the captured one are ignored while in hibernate. `enterWr` is ignored in every state except awake and idle, including the cycle in which the block is waking.
- R9: `hibActive` falls in the cycle after the wake event (the waking state lasts one cycle). On the following cycle `enterBit` clears and `wakeCause` holds the code of the source: 0 for button, 1 for pack, 2 for timer.
- R10: Whenever `hibActive` is high, `enterBit` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enterWr | input | 1 | One-cycle write of 1 to the hibernate-enter bit |
| wakeSel | input | 2 | Wake source code: 0 button, 1 pack, 2 timer, 3 none |
| pbWakeEn | input | 1 | Enables button wake |
| pbActiveLow | input | 1 | Button polarity: 1 means pressed when low |
| timerPeriod | input | TIMER_W | Wake timer period in slow ticks |
| pbIn | input | 1 | Raw push-button input (asynchronous) |
| packDetect | input | 1 | Pack-connect detect level (asynchronous) |
| slowTick | input | 1 | One-cycle slow time-base pulse |
| hibActive | output | 1 | High while in hibernate |
| enterBit | output | 1 | Read-back of the enter bit; cleared by hardware on wake |
| wakeCause | output | 2 | Code of the source that caused the last wake; 3 after reset |

## Verification
Two things can fall in the same cycle: the hardware clear of the enter bit, which happens in the single waking cycle, and a new software write to that bit. The bench places an `enterWr` pulse exactly on the waking cycle after a pack-connect wake. It then checks that the bit reads 0 and that no new entry starts. A second collision is a button press held through a full debounce while the pack source is captured; the block must stay in hibernate until the pack level arrives. Random configurations drawn from a fixed seed add refused entries and timer periods down to zero.

// File: rtl/hibWakePkg.sv
package hibWakePkg;

  typedef enum logic [1:0] {
    ST_ACTIVE    = 2'd0,
    ST_ENTERING  = 2'd1,
    ST_HIBERNATE = 2'd2,
    ST_WAKING    = 2'd3
  } hibState_t;

  localparam int SRC_W = 2;
  localparam logic [SRC_W-1:0] SRC_BUTTON = 2'd0;
  localparam logic [SRC_W-1:0] SRC_PACK   = 2'd1;
  localparam logic [SRC_W-1:0] SRC_TIMER  = 2'd2;
  localparam logic [SRC_W-1:0] SRC_NONE   = 2'd3;

  // control -> datapath
  typedef struct packed {
    logic loadTimer;
    logic clrDebounce;
    logic run;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic buttonHit;
    logic packHit;
    logic timerHit;
  } wakeHits_t;

endpackage

// File: rtl/hibWakeDatapath.sv
module hibWakeDatapath
  import hibWakePkg::*;
#(
  parameter int TIMER_W        = 16,
  parameter int DEBOUNCE_TICKS = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               pbActiveLow,
  input  logic [TIMER_W-1:0] timerPeriod,
  input  logic               pbIn,
  input  logic               packDetect,
  input  logic               slowTick,
  output wakeHits_t          hits
);

  localparam int DEB_W = $clog2(DEBOUNCE_TICKS + 1);
  localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEBOUNCE_TICKS);

  logic [SYNC_STAGES-1:0] pbSync;
  logic [SYNC_STAGES-1:0] packSync;
  logic                   pbLevel;
  logic [DEB_W-1:0]       debCnt;
  logic [TIMER_W-1:0]     timerCnt;

  // synchronisers for the two asynchronous inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pbSync   <= '0;
      packSync <= '0;
    end else begin
      pbSync   <= {pbSync[SYNC_STAGES-2:0], pbIn};
      packSync <= {packSync[SYNC_STAGES-2:0], packDetect};
    end
  end

  assign pbLevel = pbSync[SYNC_STAGES-1] ^ pbActiveLow;

  // debounce: consecutive asserted ticks, restart on any release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debCnt <= '0;
    end else if (strobe.clrDebounce || !pbLevel) begin
      debCnt <= '0;
    end else if (strobe.run && slowTick && (debCnt != DEB_LAST)) begin
      debCnt <= debCnt + 1'b1;
    end
  end

  // wake timer: reload on entry, count down on slow tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (strobe.loadTimer) begin
      timerCnt <= timerPeriod;
    end else if (strobe.run && slowTick && (timerCnt != '0)) begin
      timerCnt <= timerCnt - 1'b1;
    end
  end

  always_comb begin
    hits.buttonHit = strobe.run && (debCnt == DEB_LAST);
    hits.packHit   = strobe.run && packSync[SYNC_STAGES-1];
    hits.timerHit  = strobe.run && (timerCnt == '0);
  end

endmodule

// File: rtl/hibWakeFsm.sv
module hibWakeFsm
  import hibWakePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enterWr,
  input  logic [SRC_W-1:0] wakeSel,
  input  logic             pbWakeEn,
  input  wakeHits_t        hits,
  output ctrlStrobe_t      strobe,
  output logic             hibActive,
  output logic             enterBit,
  output logic [SRC_W-1:0] wakeCause
);

  hibState_t        state;
  logic [SRC_W-1:0] selLatched;
  logic             cfgValid;
  logic             wakeEvt;

  always_comb begin
    unique case (wakeSel)
      SRC_BUTTON: cfgValid = pbWakeEn;
      SRC_PACK:   cfgValid = 1'b1;
      SRC_TIMER:  cfgValid = 1'b1;
      default:    cfgValid = 1'b0;
    endcase
  end

  always_comb begin
    unique case (selLatched)
      SRC_BUTTON: wakeEvt = hits.buttonHit;
      SRC_PACK:   wakeEvt = hits.packHit;
      SRC_TIMER:  wakeEvt = hits.timerHit;
      default:    wakeEvt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_ACTIVE;
      selLatched <= SRC_NONE;
      enterBit   <= 1'b0;
      wakeCause  <= SRC_NONE;
    end else begin
      unique case (state)
        ST_ACTIVE: begin
          if (enterWr && cfgValid) begin
            state      <= ST_ENTERING;
            enterBit   <= 1'b1;
            selLatched <= wakeSel;
          end
        end
        ST_ENTERING:  state <= ST_HIBERNATE;
        ST_HIBERNATE: if (wakeEvt) state <= ST_WAKING;
        ST_WAKING: begin
          state     <= ST_ACTIVE;
          enterBit  <= 1'b0;
          wakeCause <= selLatched;
        end
        default: state <= ST_ACTIVE;
      endcase
    end
  end

  always_comb begin
    strobe.loadTimer   = (state == ST_ENTERING);
    strobe.clrDebounce = (state == ST_ENTERING);
    strobe.run         = (state == ST_HIBERNATE);
  end

  assign hibActive = (state == ST_HIBERNATE);

endmodule

// File: rtl/hibWakeCtrl.sv
module hibWakeCtrl
  import hibWakePkg::*;
#(
  parameter int TIMER_W        = 16,
  parameter int DEBOUNCE_TICKS = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enterWr,
  input  logic [1:0]         wakeSel,
  input  logic               pbWakeEn,
  input  logic               pbActiveLow,
  input  logic [TIMER_W-1:0] timerPeriod,
  input  logic               pbIn,
  input  logic               packDetect,
  input  logic               slowTick,
  output logic               hibActive,
  output logic               enterBit,
  output logic [1:0]         wakeCause
);

  ctrlStrobe_t strobe;
  wakeHits_t   hits;
  logic        polLatched;

  // polarity captured at entry so it cannot change mid-hibernate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          polLatched <= 1'b0;
    else if (!enterBit && !hibActive)   polLatched <= pbActiveLow;
  end

  hibWakeFsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .enterWr   (enterWr),
    .wakeSel   (wakeSel),
    .pbWakeEn  (pbWakeEn),
    .hits      (hits),
    .strobe    (strobe),
    .hibActive (hibActive),
    .enterBit  (enterBit),
    .wakeCause (wakeCause)
  );

  hibWakeDatapath #(
    .TIMER_W        (TIMER_W),
    .DEBOUNCE_TICKS (DEBOUNCE_TICKS),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pbActiveLow (polLatched),
    .timerPeriod (timerPeriod),
    .pbIn        (pbIn),
    .packDetect  (packDetect),
    .slowTick    (slowTick),
    .hits        (hits)
  );

endmodule

// File: rtl/hibWakeCtrlChk.sv
module hibWakeCtrlChk (
  input logic       clk,
  input logic       rstN,
  input logic       enterWr,
  input logic [1:0] wakeSel,
  input logic       hibActive,
  input logic       enterBit,
  input logic [1:0] wakeCause
);

  // R10
  hib_implies_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    hibActive |-> enterBit);

  // R2
  entry_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enterBit) |=> hibActive);

  // R3
  refuse_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enterWr && !enterBit && (wakeSel == 2'd3)) |=> !enterBit);

  // R9
  clear_after_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hibActive) |=> !enterBit);

  // R9
  cause_on_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wakeCause) |-> ($past(enterBit) && !enterBit));

  // R8
  enter_ignored_in_hib_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hibActive && enterWr) |=> enterBit);

endmodule

bind hibWakeCtrl hibWakeCtrlChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enterWr   (enterWr),
  .wakeSel   (wakeSel),
  .hibActive (hibActive),
  .enterBit  (enterBit),
  .wakeCause (wakeCause)
);

// File: tb/hibWakeCtrl_bench.sv
module hibWakeCtrl_bench;

  localparam int TW  = 16;
  localparam int DEB = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enterWr = 1'b0;
  logic [1:0]    wakeSel = 2'd2;
  logic          pbWakeEn = 1'b0;
  logic          pbActiveLow = 1'b0;
  logic [TW-1:0] timerPeriod = '0;
  logic          pbIn = 1'b0;
  logic          packDetect = 1'b0;
  logic          slowTick = 1'b0;
  logic          hibActive;
  logic          enterBit;
  logic [1:0]    wakeCause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hibWakeCtrl #(.TIMER_W(TW), .DEBOUNCE_TICKS(DEB)) u_hibWakeCtrl (
    .clk(clk), .rstN(rstN), .enterWr(enterWr), .wakeSel(wakeSel),
    .pbWakeEn(pbWakeEn), .pbActiveLow(pbActiveLow), .timerPeriod(timerPeriod),
    .pbIn(pbIn), .packDetect(packDetect), .slowTick(slowTick),
    .hibActive(hibActive), .enterBit(enterBit), .wakeCause(wakeCause)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    slowTick = 1'b1;
    cyc(1);
    slowTick = 1'b0;
  endtask

  function automatic bit expValid(input logic [1:0] sel, input logic en);
    return (sel == 2'd1) || (sel == 2'd2) || (sel == 2'd0 && en);
  endfunction

  function automatic logic pressLevel(input logic low);
    return low ? 1'b0 : 1'b1;
  endfunction

  task automatic doEnter(input bit v);
    enterWr = 1'b1;
    cyc(1);
    enterWr = 1'b0;
    check(v ? "R2 enter bit set" : "R3 entry refused", enterBit, v);
    cyc(1);
    check(v ? "R2 hibernate after one cycle" : "R3 no hibernate", hibActive, v);
  endtask

  // called at the negedge right after the wake event edge
  task automatic finishWake(input int cause);
    check("R9 hibActive falls", hibActive, 0);
    check("R9 enter bit held in waking", enterBit, 1);
    cyc(1);
    check("R9 enter bit cleared", enterBit, 0);
    check("R9 wake cause", wakeCause, cause);
  endtask

  task automatic runTimer(input int per);
    for (int i = 1; i < per; i++) begin
      tick();
      check("R7 still asleep before period", hibActive, 1);
    end
    if (per > 0) begin
      tick();
      check("R7 asleep at last tick edge", hibActive, 1);
    end
    cyc(1);
    finishWake(2);
  endtask

  task automatic runButton(input logic low);
    pbIn = pressLevel(low);
    cyc(3);
    for (int i = 1; i < DEB; i++) begin
      tick();
      check("R4 debounce not yet done", hibActive, 1);
    end
    tick();
    check("R4 asleep at final debounce tick", hibActive, 1);
    cyc(1);
    finishWake(0);
    pbIn = ~pressLevel(low);
    cyc(4);
  endtask

  task automatic runPack();
    packDetect = 1'b1;
    cyc(2);
    check("R6 pack synchroniser delay", hibActive, 1);
    cyc(1);
    finishWake(1);
    packDetect = 1'b0;
    cyc(4);
  endtask

  task automatic setCfg(input logic [1:0] sel, input logic en, input logic low, input int per);
    wakeSel = sel; pbWakeEn = en; pbActiveLow = low;
    timerPeriod = TW'(per); pbIn = ~pressLevel(low);
    cyc(3);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4711);
    cyc(3);
    check("R1 reset hibActive", hibActive, 0);
    check("R1 reset enterBit", enterBit, 0);
    check("R1 reset wakeCause", wakeCause, 3);
    rstN = 1'b1;
    cyc(1);
    check("R1 after reset wakeCause", wakeCause, 3);

    // R3: no source, and button without enable
    setCfg(2'd3, 1'b1, 1'b0, 0);
    doEnter(0);
    setCfg(2'd0, 1'b0, 1'b0, 0);
    doEnter(0);

    // R7: timer period 3, twice to see reload; then period 0
    setCfg(2'd2, 1'b0, 1'b0, 3);
    doEnter(1); runTimer(3);
    doEnter(1); runTimer(3);
    setCfg(2'd2, 1'b0, 1'b0, 0);
    doEnter(1); runTimer(0);

    // R4: glitchy press restarts debounce
    setCfg(2'd0, 1'b1, 1'b0, 0);
    doEnter(1);
    pbIn = 1'b1; cyc(3);
    tick(); tick();
    pbIn = 1'b0; cyc(3);
    check("R4 release keeps asleep", hibActive, 1);
    runButton(1'b0);

    // R5: active-low button
    setCfg(2'd0, 1'b1, 1'b1, 0);
    doEnter(1);
    runButton(1'b1);

    // R8: pack captured, button and new select ignored, enterWr ignored
    setCfg(2'd1, 1'b1, 1'b0, 0);
    doEnter(1);
    wakeSel = 2'd0;
    pbIn = 1'b1; cyc(3);
    for (int i = 0; i <= DEB; i++) tick();
    cyc(2);
    check("R8 button ignored while pack captured", hibActive, 1);
    enterWr = 1'b1; cyc(1); enterWr = 1'b0;
    check("R8 enterWr ignored in hibernate", enterBit, 1);
    pbIn = 1'b0; cyc(3);
    // pack wake with enterWr landing on the waking cycle
    packDetect = 1'b1;
    cyc(3);
    check("R6 pack wakes", hibActive, 0);
    enterWr = 1'b1; cyc(1); enterWr = 1'b0;
    check("R8 waking-cycle write cleared", enterBit, 0);
    check("R9 pack cause", wakeCause, 1);
    cyc(1);
    check("R8 no re-entry from waking write", enterBit, 0);
    packDetect = 1'b0; cyc(4);

    // random configurations
    for (int it = 0; it < 40; it++) begin
      logic [1:0] sel;
      logic en;
      logic low;
      int per;
      sel = 2'($urandom % 4);
      en  = 1'($urandom % 2);
      low = 1'($urandom % 2);
      per = int'($urandom % 6);
      setCfg(sel, en, low, per);
      doEnter(expValid(sel, en));
      if (expValid(sel, en)) begin
        wakeSel = 2'($urandom % 4);
        case (sel)
          2'd0: runButton(low);
          2'd1: runPack();
          default: runTimer(per);
        endcase
      end else begin
        cyc(2);
        check("R3 refused stays awake", hibActive, 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule